// File: doc/BRIEF.md
# Flash Controller FIFO Status and Interrupt Unit

This unit sits between a serial flash engine, a host register port and the interrupt controller. It holds the data FIFO that both sides share, derives two request events from a programmable fill threshold, records five events in sticky flags, and drives one interrupt line through a per-source mask. The host empties or fills the FIFO through a data register. The engine uses its own push and pop strobes and signals the end of a transfer with a one-cycle pulse.

Software programs the threshold and masks, then starts a transfer. It services the request events by moving words through the data register. It acknowledges events by writing ones to the clear register. A status read returns the flags and the current number of stored words. A flush command drops everything held in the FIFO.

Top module: `flashevt_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, every flag reads 0, the occupancy reads 0 and `irq` is 0. The mask reads 0x1F (all sources off) and the threshold reads DEPTH-1 (63).
- R2: Words leave the FIFO in the order they entered, whichever side pushed or popped them. The status register (word address 1) reports the number of stored words in bits 22:16.
- R3: A push while DEPTH words are stored sets status bit 1 (overflow). It stores nothing and leaves the occupancy and all stored words unchanged.
- R4: A pop while the FIFO is empty sets status bit 0 (underflow) and leaves the occupancy at 0.
- R5: Status bit 2 (receive request) is set one cycle after any cycle in which the occupancy is strictly greater than the threshold.
- R6: Status bit 3 (transmit request) is set one cycle after any cycle in which the free space (DEPTH minus occupancy) is strictly greater than the threshold.
- R7: A one-cycle pulse on `eng_done` sets status bit 4 (end).
- R8: A write to the clear register (word address 2) clears each flag whose data bit is 1 and leaves flags whose bit is 0. If a flag's event holds in the same cycle, the flag stays set.
- R9: `irq` is the OR of the flags whose mask bit is 0, registered one cycle after the flags and mask it is computed from. A mask bit of 1 keeps its source off the line.
- R10: Writing 1 to bit 0 of the command register (word address 4) empties the FIFO. The occupancy reads 0 and the next word pushed is the next word popped.
- R11: Register map by word address: 0 threshold in bits 5:0 (read/write), 1 status (read), 2 clear (write), 3 mask in bits 4:0 (read/write), 4 command (write), 5 data (a write pushes, a read pops and returns the head word). Mask bits above bit 4 are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | AW (3) | Register word address |
| reg_wdata | input | REG_W (32) | Register write data |
| reg_rdata | output | REG_W (32) | Register read data, valid in the cycle of the access |
| eng_push | input | 1 | Engine pushes `eng_wdata` into the FIFO |
| eng_wdata | input | DATA_W (32) | Engine push word |
| eng_pop | input | 1 | Engine pops the head word |
| eng_rdata | output | DATA_W (32) | FIFO head word, 0 when empty |
| eng_done | input | 1 | End-of-transfer pulse from the engine |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench keeps the default DEPTH of 64 and the 32-bit data and register widths, so the six-bit threshold spans its full range. The common value of 63 puts both request boundaries at the extreme fill levels: completely full and completely empty. Filling all 64 entries reaches the overflow case and the point where receive request first triggers. The bench then lowers the threshold to 2 to check the strict greater-than boundary at a small fill level. A scoreboard queue follows every word through mixed host and engine pushes and pops, across overflow, underflow and flush.

// File: rtl/flashevt_pkg.sv
package flashevt_pkg;

    // Event bit positions; software and the clear/mask registers share them.
    localparam int unsigned EV_UDF  = 0;
    localparam int unsigned EV_OVF  = 1;
    localparam int unsigned EV_RXRQ = 2;
    localparam int unsigned EV_TXRQ = 3;
    localparam int unsigned EV_END  = 4;
    localparam int unsigned EV_NUM  = 5;

    // Position of the occupancy field inside the status word.
    localparam int unsigned OCC_LSB = 16;

    typedef enum logic [2:0] {
        RA_CFG  = 3'd0,
        RA_STAT = 3'd1,
        RA_CLR  = 3'd2,
        RA_MASK = 3'd3,
        RA_CMD  = 3'd4,
        RA_DATA = 3'd5
    } reg_addr_e;

    // Packed so that the member order matches the bit positions above.
    typedef struct packed {
        logic end_ev;
        logic tx_req;
        logic rx_req;
        logic ovf;
        logic udf;
    } evt_t;

    function automatic logic [EV_NUM-1:0] evt_bits(evt_t e);
        return e;
    endfunction

endpackage

// File: rtl/flashevt_fifo.sv
module flashevt_fifo #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_o,
    output logic              udf_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [CNT_W-1:0]  cnt;
    logic              full, empty, do_push, do_pop;

    always_comb begin
        full    = (cnt == FULL);
        empty   = (cnt == '0);
        do_push = push_i & ~full  & ~flush_i;
        do_pop  = pop_i  & ~empty & ~flush_i;
        ovf_o   = push_i & full  & ~flush_i;
        udf_o   = pop_i  & empty & ~flush_i;
        head_o  = empty ? '0 : mem[rp];
        count_o = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data_i;
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);
    a_r3_full_push_holds: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && !flush_i && full) |=> (cnt == FULL));
    a_r4_empty_pop_holds: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && !flush_i && empty) |=> (cnt == '0));
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (cnt == '0));

endmodule

// File: rtl/flashevt_status.sv
module flashevt_status #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         mask_we_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] flags_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o <= '0;
            mask_o  <= '1;
            irq_o   <= 1'b0;
        end else begin
            flags_o <= set_i | (flags_o & ~clr_i);
            if (mask_we_i) mask_o <= mask_i;
            irq_o <= |(flags_o & ~mask_o);
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_chk
        a_r8_clear_takes: assert property (@(posedge clk) disable iff (rst)
            (clr_i[k] && !set_i[k]) |=> !flags_o[k]);
        a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_i[k] |=> flags_o[k]);
    end

    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        ((flags_o & ~mask_o) == '0) |=> !irq_o);
    a_r9_pending_raises: assert property (@(posedge clk) disable iff (rst)
        ((flags_o & ~mask_o) != '0) |=> irq_o);

endmodule

// File: rtl/flashevt_unit.sv
module flashevt_unit
    import flashevt_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REG_W  = 32,
    parameter int unsigned AW     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              eng_push,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic              eng_pop,
    output logic [DATA_W-1:0] eng_rdata,
    input  logic              eng_done,
    output logic              irq
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned THR_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic              host_wr, host_rd;
    logic              hit_cfg, hit_clr, hit_mask, hit_cmd, hit_data;
    logic [THR_W-1:0]  thr;
    logic              f_push, f_pop, f_flush, f_ovf, f_udf;
    logic [DATA_W-1:0] f_wdata, f_head;
    logic [CNT_W-1:0]  occ, free_sp;
    evt_t              ev_set, st;
    logic [EV_NUM-1:0] clr_vec, flags, mask;

    always_comb begin
        host_wr  = reg_en &  reg_we;
        host_rd  = reg_en & ~reg_we;
        hit_cfg  = (reg_addr == AW'(RA_CFG));
        hit_clr  = (reg_addr == AW'(RA_CLR));
        hit_mask = (reg_addr == AW'(RA_MASK));
        hit_cmd  = (reg_addr == AW'(RA_CMD));
        hit_data = (reg_addr == AW'(RA_DATA));
        f_push   = eng_push | (host_wr & hit_data);
        f_pop    = eng_pop  | (host_rd & hit_data);
        f_wdata  = eng_push ? eng_wdata : reg_wdata[DATA_W-1:0];
        f_flush  = host_wr & hit_cmd & reg_wdata[0];
        clr_vec  = (host_wr & hit_clr) ? reg_wdata[EV_NUM-1:0] : '0;
        free_sp  = FULL - occ;
    end

    always_ff @(posedge clk) begin
        if (rst)                    thr <= '1;
        else if (host_wr & hit_cfg) thr <= reg_wdata[THR_W-1:0];
    end

    flashevt_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk         (clk),
        .rst         (rst),
        .flush_i     (f_flush),
        .push_i      (f_push),
        .push_data_i (f_wdata),
        .pop_i       (f_pop),
        .head_o      (f_head),
        .count_o     (occ),
        .ovf_o       (f_ovf),
        .udf_o       (f_udf)
    );

    always_comb begin
        ev_set.udf    = f_udf;
        ev_set.ovf    = f_ovf;
        ev_set.rx_req = (occ > CNT_W'(thr));
        ev_set.tx_req = (free_sp > CNT_W'(thr));
        ev_set.end_ev = eng_done;
    end

    flashevt_status #(.N(EV_NUM)) u_status (
        .clk       (clk),
        .rst       (rst),
        .set_i     (evt_bits(ev_set)),
        .clr_i     (clr_vec),
        .mask_we_i (host_wr & hit_mask),
        .mask_i    (reg_wdata[EV_NUM-1:0]),
        .flags_o   (flags),
        .mask_o    (mask),
        .irq_o     (irq)
    );

    assign st        = evt_t'(flags);
    assign eng_rdata = f_head;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(RA_CFG):  reg_rdata[THR_W-1:0] = thr;
            AW'(RA_STAT): begin
                reg_rdata[EV_NUM-1:0]       = flags;
                reg_rdata[OCC_LSB +: CNT_W] = occ;
            end
            AW'(RA_MASK): reg_rdata[EV_NUM-1:0]  = mask;
            AW'(RA_DATA): reg_rdata[DATA_W-1:0]  = f_head;
            default:      reg_rdata = '0;
        endcase
    end

    a_r5_rx_level_sets: assert property (@(posedge clk) disable iff (rst)
        (occ > CNT_W'(thr)) |=> st.rx_req);
    a_r6_tx_level_sets: assert property (@(posedge clk) disable iff (rst)
        (free_sp > CNT_W'(thr)) |=> st.tx_req);
    a_r7_end_sets: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> st.end_ev);
    a_r3_ovf_sets: assert property (@(posedge clk) disable iff (rst)
        (f_push && !f_flush && occ == FULL) |=> st.ovf);
    a_r4_udf_sets: assert property (@(posedge clk) disable iff (rst)
        (f_pop && !f_flush && occ == '0) |=> st.udf);

endmodule

// File: tb/test_flashevt_unit.sv
module test_flashevt_unit;

    localparam int unsigned DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_push = 1'b0, eng_pop = 1'b0, eng_done = 1'b0;
    logic [31:0] eng_wdata = '0;
    logic [31:0] eng_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int mcount = 0;
    logic [31:0] exp_q[$];
    logic        mon_pop = 1'b0;
    logic [31:0] mon_data = '0;

    always #10 clk = ~clk;

    flashevt_unit #(.DEPTH(DEPTH)) i_flashevt_unit (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop),
        .eng_rdata(eng_rdata), .eng_done(eng_done), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #2 d = reg_rdata;
        @(posedge clk); #1;
        reg_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver side of the scoreboard: stored words enter the queue.
    task automatic host_push(input logic [31:0] d);
        wr(3'd5, d);
        if (mcount < DEPTH) begin exp_q.push_back(d); mcount++; end
    endtask

    task automatic eng_push_word(input logic [31:0] d);
        @(negedge clk);
        eng_push = 1'b1; eng_wdata = d;
        @(posedge clk); #1;
        eng_push = 1'b0;
        if (mcount < DEPTH) begin exp_q.push_back(d); mcount++; end
    endtask

    task automatic host_pop();
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = 3'd5;
        #2 mon_data = reg_rdata;
        mon_pop = (mcount > 0);
        if (mcount > 0) mcount--;
        @(posedge clk); #1;
        reg_en = 1'b0; mon_pop = 1'b0;
    endtask

    task automatic eng_pop_word();
        @(negedge clk);
        eng_pop = 1'b1;
        #2 mon_data = eng_rdata;
        mon_pop = (mcount > 0);
        if (mcount > 0) mcount--;
        @(posedge clk); #1;
        eng_pop = 1'b0; mon_pop = 1'b0;
    endtask

    // Monitor side of the scoreboard: each popped word against the queue head.
    always @(posedge clk) begin
        if (mon_pop) begin
            if (exp_q.size() == 0) chk("R2 pop with empty model", mon_data, 32'hFFFF_FFFF);
            else chk("R2 order", mon_data, exp_q.pop_front());
        end
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        // R1: state while reset is held
        idle(2);
        rd(3'd1, v); chk("R1 status in reset", v, 32'h0);
        rd(3'd3, v); chk("R1 mask in reset", v, 32'h1F);
        rd(3'd0, v); chk("R1 threshold in reset", v, 32'd63);
        chk("R1 irq in reset", {31'b0, irq}, 32'h0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        idle(1);

        // R6: empty FIFO has 64 free > 63
        rd(3'd1, v); chk("R6 tx request when empty", v, 32'h0000_0008);
        wr(3'd2, 32'h0); idle(1);
        rd(3'd1, v); chk("R8 zero bits keep flags", v, 32'h0000_0008);
        wr(3'd2, 32'h8); idle(1);
        rd(3'd1, v); chk("R8 set wins over clear", v, 32'h0000_0008);

        // R2/R6 boundary: one word, free 63 not > 63
        host_push(32'hA000_0000); idle(1);
        wr(3'd2, 32'h8); idle(1);
        rd(3'd1, v); chk("R6 boundary and R2 occupancy", v, 32'h0001_0000);

        // R5: fill to 64
        for (int i = 0; i < 63; i++) eng_push_word(32'h100 + i);
        idle(2);
        rd(3'd1, v); chk("R5 rx request at full", v, 32'h0040_0004);

        // R3: overflow
        host_push(32'h0000_DEAD); idle(2);
        rd(3'd1, v); chk("R3 overflow flag, occupancy held", v, 32'h0040_0006);

        // R2/R3: drain with mixed sides; first word intact
        for (int i = 0; i < DEPTH; i++) begin
            if (i % 2 == 0) host_pop(); else eng_pop_word();
        end
        chk("R2 scoreboard drained", exp_q.size(), 32'd0);

        // R4: underflow
        host_pop(); idle(2);
        rd(3'd1, v); chk("R4 underflow flag, occupancy zero", v, 32'h0000_000F);
        wr(3'd2, 32'h1F); idle(1);
        rd(3'd1, v); chk("R8 clear all, tx re-set", v, 32'h0000_0008);

        // R7: end pulse
        @(negedge clk); eng_done = 1'b1;
        @(posedge clk); #1; eng_done = 1'b0;
        idle(1);
        rd(3'd1, v); chk("R7 end flag", v, 32'h0000_0018);

        // R9: masking and one-cycle latency
        chk("R9 all masked keeps irq low", {31'b0, irq}, 32'h0);
        wr(3'd3, 32'hFFFF_FFEF);
        chk("R9 irq not yet raised", {31'b0, irq}, 32'h0);
        idle(1);
        chk("R9 irq raised one cycle later", {31'b0, irq}, 32'h1);
        rd(3'd3, v); chk("R11 mask stores five bits", v, 32'h0000_000F);
        wr(3'd2, 32'h10); idle(2);
        chk("R9 irq drops after clear", {31'b0, irq}, 32'h0);
        wr(3'd3, 32'h17); idle(2);
        chk("R9 tx source enabled", {31'b0, irq}, 32'h1);
        wr(3'd3, 32'h1F); idle(2);
        chk("R9 masked again", {31'b0, irq}, 32'h0);

        // R5 boundary at threshold 2
        wr(3'd0, 32'h2);
        rd(3'd0, v); chk("R11 threshold readback", v, 32'h2);
        eng_push_word(32'h200); eng_push_word(32'h201);
        idle(1);
        wr(3'd2, 32'h1F); idle(2);
        rd(3'd1, v); chk("R5 occupancy equal to threshold", v, 32'h0002_0008);
        host_push(32'h202); idle(2);
        rd(3'd1, v); chk("R5 occupancy above threshold", v, 32'h0003_000C);

        // R10: flush
        wr(3'd4, 32'h1);
        exp_q.delete(); mcount = 0;
        idle(1);
        rd(3'd1, v); chk("R10 flush empties", v, 32'h0000_000C);
        host_push(32'h300);
        host_pop();
        idle(1);
        rd(3'd1, v); chk("R10 occupancy after reuse", v[22:16], 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule